// File: doc/BRIEF.md
# Voice Codec Control Register File

This block holds the configuration state of a voice codec. It has eight byte-wide registers at addresses 0 to 7 and turns their bits into individual control lines. These lines cover gain codes, muting, power-down, companding law, channel enables, clock selection and loopback. A synchronous host port writes the registers on a clock edge and reads them back combinationally. The block also drives the output-enable of the serial data pin. That enable is qualified by a frame strobe.

One bit of the power/mute register (address 3) works as a software reset. Setting it returns every register to its default on the same edge. While it stays set, the rest of the block is frozen at its defaults. The host port remains usable, but only to clear that bit. Clearing the bit does not load the other bits of address 3, so the host must write address 3 a second time to program it. The hardware reset input is active low. It is applied asynchronously and released synchronously, and it also ends a software reset.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: While `rst_ni` is low, `full_pwrdn_o` is 1 and `sdo_oe_o` is 0. After reset is released, every address reads 0x00.
- R2: A write stores only the implemented bits, and reserved bits always read 0. The implemented-bit masks are: address 0 = 0xFF, 1 = 0x07, 2 = 0x01, 3 = 0xEF, 4 = 0xFF, 5 = 0xFF, 6 = 0xFF, 7 = 0x0C.
- R3: `rdata_o` is 0x00 whenever `rd_en_i` is low. When `rd_en_i` is high, it shows the addressed register in the same cycle.
- R4: A write to address 3 with bit 5 set starts software reset on that clock edge and clears every register. Address 3 then reads 0x20 and `soft_rst_o` is 1.
- R5: During software reset, writes to any address other than 3 are ignored. Writes to address 3 with bit 5 set leave its other bits at 0.
- R6: During software reset, a write to address 3 with bit 5 clear ends the reset and leaves address 3 at 0x00, whatever the other data bits were. A second write to address 3 then programs it.
- R7: During software reset, every decoded output is at its default of 0 and `sdo_oe_o` is 0.
- R8: `full_pwrdn_o` is 1 only when both bit 7 and bit 6 of address 3 are 1, or when hardware reset is active. Either bit alone is not enough.
- R9: `sdo_oe_o` is 1 only while `frame_strobe_i` is 1, the block is out of both resets, and it is not fully powered down.
- R10: Each control output follows a fixed field of the register file:
  - Address 0: bits 7:4 drive `rx_gain_o` and bits 3:0 drive `tx_gain_o`.
  - Address 1: bits 2:0 drive `side_gain_o`.
  - Address 2: bit 0 drives `drv_gain_o`.
  - Address 3: bit 7 drives `pd_front_o`, bit 6 `pd_drive_o`, bit 3 `tx_mute_o`, bit 2 `rx_mute_o`, bit 1 `tx_bank_o` and bit 0 `rx_bank_o`.
  - Address 4: bit 7 drives `cch_en_o`, bit 6 `dch_en_o`, bit 5 `dch_wide_o`, bit 4 `alaw_o` (1 selects A-law, 0 selects μ-law), bit 3 `signmag_o` and bits 2:0 `clk_sel_o`.
  - Addresses 5 and 6 drive `cch_data_o` and `dch_data_o`.
  - Address 7: bit 3 drives `loop_pcm_o` and bit 2 drives `loop_en_o`.
- R11: Asserting the hardware reset during software reset ends the software reset. After release, address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read enable |
| rdata_o | output | 8 | Read data |
| frame_strobe_i | input | 1 | Channel frame strobe |
| sdo_oe_o | output | 1 | Serial data pin output enable |
| soft_rst_o | output | 1 | Software reset active |
| full_pwrdn_o | output | 1 | Full power-down |
| pd_front_o | output | 1 | Front-end power-down bit |
| pd_drive_o | output | 1 | Driver power-down bit |
| tx_mute_o | output | 1 | Transmit mute |
| rx_mute_o | output | 1 | Receive mute |
| tx_bank_o | output | 1 | Transmit bank select |
| rx_bank_o | output | 1 | Receive bank select |
| rx_gain_o | output | 4 | Receive gain code |
| tx_gain_o | output | 4 | Transmit gain code |
| side_gain_o | output | 3 | Sidetone gain code |
| drv_gain_o | output | 1 | Driver gain select |
| cch_en_o | output | 1 | Control channel enable |
| dch_en_o | output | 1 | Data channel enable |
| dch_wide_o | output | 1 | Data channel 8-bit width |
| alaw_o | output | 1 | Companding law, 1 = A-law |
| signmag_o | output | 1 | Sign-magnitude coding select |
| clk_sel_o | output | 3 | Serial clock select |
| cch_data_o | output | 8 | Control channel byte |
| dch_data_o | output | 8 | Data channel byte |
| loop_en_o | output | 1 | Loopback enable |
| loop_pcm_o | output | 1 | Loopback point select |

## Verification
The hardest state to reach from the ports is the exit from software reset. The bench has to show that one write with bit 5 clear releases the reset, yet none of the data bits sent with that write land in address 3. To get there, the stimulus first loads non-zero values into every register. It then enters software reset with a write whose other bits are also set. Next it sends a stray write to another address and a second reset write, and the bench checks that both are ignored. The exit write carries live mute and bank bits, and the bench reads address 3 back as zero before a second write is shown to take effect. A separate scenario pulls the hardware reset while software reset is active and checks that the software reset is cleared.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam int GAIN_ADDR = 0;
  localparam int SIDE_ADDR = 1;
  localparam int DRV_ADDR  = 2;
  localparam int CTL1_ADDR = 3;
  localparam int CTL2_ADDR = 4;
  localparam int CCH_ADDR  = 5;
  localparam int DCH_ADDR  = 6;
  localparam int LOOP_ADDR = 7;

  // bit positions in the power/mute register
  localparam int PDF_BIT   = 7;
  localparam int PDD_BIT   = 6;
  localparam int SRST_BIT  = 5;
  localparam int TXM_BIT   = 3;
  localparam int RXM_BIT   = 2;
  localparam int TXB_BIT   = 1;
  localparam int RXB_BIT   = 0;

  // bit positions in the format register
  localparam int CEN_BIT   = 7;
  localparam int DEN_BIT   = 6;
  localparam int WIDE_BIT  = 5;
  localparam int LAW_BIT   = 4;
  localparam int SMAG_BIT  = 3;

  localparam int LPCM_BIT  = 3;
  localparam int LEN_BIT   = 2;

  typedef logic [DATA_W-1:0] byte_t;

  function automatic byte_t reg_wmask(input int idx);
    case (idx)
      GAIN_ADDR: reg_wmask = 8'hFF;
      SIDE_ADDR: reg_wmask = 8'h07;
      DRV_ADDR:  reg_wmask = 8'h01;
      CTL1_ADDR: reg_wmask = 8'hEF;
      CTL2_ADDR: reg_wmask = 8'hFF;
      CCH_ADDR:  reg_wmask = 8'hFF;
      DCH_ADDR:  reg_wmask = 8'hFF;
      LOOP_ADDR: reg_wmask = 8'h0C;
      default:   reg_wmask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_rst_sync.sv
module codec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_ctrl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NR-1:0][DW-1:0] regs_o,
  output logic               srst_o
);
  localparam logic [AW-1:0] CTL1_A   = AW'(CTL1_ADDR);
  localparam logic [DW-1:0] SRST_VAL = DW'(1) << SRST_BIT;

  logic hit_ctl1;
  logic srst_q;
  logic srst_set;
  logic srst_clr;

  assign srst_q   = regs_o[CTL1_ADDR][SRST_BIT];
  assign hit_ctl1 = wr_en_i && (addr_i == CTL1_A);
  assign srst_set = hit_ctl1 && wdata_i[SRST_BIT];
  assign srst_clr = hit_ctl1 && !wdata_i[SRST_BIT] && srst_q;

  for (genvar gi = 0; gi < NR; gi++) begin : g_reg
    localparam logic [DW-1:0] MASK = DW'(reg_wmask(gi));
    localparam bit IS_CTL1 = (gi == CTL1_ADDR);
    logic [DW-1:0] reg_q;
    logic [DW-1:0] reg_d;
    logic          reg_en;

    always_comb begin
      reg_en = srst_set
             || (wr_en_i && (addr_i == AW'(gi)) && !srst_q)
             || (IS_CTL1 && srst_clr);
      if (srst_set) begin
        reg_d = IS_CTL1 ? SRST_VAL : '0;
      end else if (IS_CTL1 && srst_clr) begin
        reg_d = '0;
      end else begin
        reg_d = wdata_i & MASK;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q <= '0;
      end else if (reg_en) begin
        reg_q <= reg_d;
      end
    end

    assign regs_o[gi] = reg_q;
  end

  assign srst_o = srst_q;
endmodule

// File: rtl/codec_rd_mux.sv
module codec_rd_mux
  import codec_ctrl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGS
) (
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [NR-1:0][DW-1:0] regs_i,
  output logic [DW-1:0]         rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      rdata_o = regs_i[addr_i];
    end
  end
endmodule

// File: rtl/codec_ctrl_decode.sv
module codec_ctrl_decode
  import codec_ctrl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGS
) (
  input  logic                  core_rst_ni,
  input  logic                  frame_strobe_i,
  input  logic [NR-1:0][DW-1:0] regs_i,
  output logic                  sdo_oe_o,
  output logic                  soft_rst_o,
  output logic                  full_pwrdn_o,
  output logic                  pd_front_o,
  output logic                  pd_drive_o,
  output logic                  tx_mute_o,
  output logic                  rx_mute_o,
  output logic                  tx_bank_o,
  output logic                  rx_bank_o,
  output logic [3:0]            rx_gain_o,
  output logic [3:0]            tx_gain_o,
  output logic [2:0]            side_gain_o,
  output logic                  drv_gain_o,
  output logic                  cch_en_o,
  output logic                  dch_en_o,
  output logic                  dch_wide_o,
  output logic                  alaw_o,
  output logic                  signmag_o,
  output logic [2:0]            clk_sel_o,
  output logic [DW-1:0]         cch_data_o,
  output logic [DW-1:0]         dch_data_o,
  output logic                  loop_en_o,
  output logic                  loop_pcm_o
);
  logic [DW-1:0] ctl1;
  logic [DW-1:0] ctl2;

  assign ctl1 = regs_i[CTL1_ADDR];
  assign ctl2 = regs_i[CTL2_ADDR];

  always_comb begin
    soft_rst_o   = ctl1[SRST_BIT];
    pd_front_o   = ctl1[PDF_BIT];
    pd_drive_o   = ctl1[PDD_BIT];
    tx_mute_o    = ctl1[TXM_BIT];
    rx_mute_o    = ctl1[RXM_BIT];
    tx_bank_o    = ctl1[TXB_BIT];
    rx_bank_o    = ctl1[RXB_BIT];
    full_pwrdn_o = !core_rst_ni || (ctl1[PDF_BIT] && ctl1[PDD_BIT]);
    sdo_oe_o     = frame_strobe_i && core_rst_ni && !ctl1[SRST_BIT]
                && !(ctl1[PDF_BIT] && ctl1[PDD_BIT]);

    rx_gain_o    = regs_i[GAIN_ADDR][7:4];
    tx_gain_o    = regs_i[GAIN_ADDR][3:0];
    side_gain_o  = regs_i[SIDE_ADDR][2:0];
    drv_gain_o   = regs_i[DRV_ADDR][0];

    cch_en_o     = ctl2[CEN_BIT];
    dch_en_o     = ctl2[DEN_BIT];
    dch_wide_o   = ctl2[WIDE_BIT];
    alaw_o       = ctl2[LAW_BIT];
    signmag_o    = ctl2[SMAG_BIT];
    clk_sel_o    = ctl2[2:0];

    cch_data_o   = regs_i[CCH_ADDR];
    dch_data_o   = regs_i[DCH_ADDR];
    loop_en_o    = regs_i[LOOP_ADDR][LEN_BIT];
    loop_pcm_o   = regs_i[LOOP_ADDR][LPCM_BIT];
  end
endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
  import codec_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_strobe_i,
  output logic              sdo_oe_o,
  output logic              soft_rst_o,
  output logic              full_pwrdn_o,
  output logic              pd_front_o,
  output logic              pd_drive_o,
  output logic              tx_mute_o,
  output logic              rx_mute_o,
  output logic              tx_bank_o,
  output logic              rx_bank_o,
  output logic [3:0]        rx_gain_o,
  output logic [3:0]        tx_gain_o,
  output logic [2:0]        side_gain_o,
  output logic              drv_gain_o,
  output logic              cch_en_o,
  output logic              dch_en_o,
  output logic              dch_wide_o,
  output logic              alaw_o,
  output logic              signmag_o,
  output logic [2:0]        clk_sel_o,
  output logic [DATA_W-1:0] cch_data_o,
  output logic [DATA_W-1:0] dch_data_o,
  output logic              loop_en_o,
  output logic              loop_pcm_o
);
  logic                            core_rst_n;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            srst_unused;

  codec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (core_rst_n)
  );

  codec_reg_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (core_rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .regs_o  (regs),
    .srst_o  (srst_unused)
  );

  codec_rd_mux u_rd_mux (
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .regs_i  (regs),
    .rdata_o (rdata_o)
  );

  codec_ctrl_decode u_decode (
    .core_rst_ni    (core_rst_n),
    .frame_strobe_i (frame_strobe_i),
    .regs_i         (regs),
    .sdo_oe_o       (sdo_oe_o),
    .soft_rst_o     (soft_rst_o),
    .full_pwrdn_o   (full_pwrdn_o),
    .pd_front_o     (pd_front_o),
    .pd_drive_o     (pd_drive_o),
    .tx_mute_o      (tx_mute_o),
    .rx_mute_o      (rx_mute_o),
    .tx_bank_o      (tx_bank_o),
    .rx_bank_o      (rx_bank_o),
    .rx_gain_o      (rx_gain_o),
    .tx_gain_o      (tx_gain_o),
    .side_gain_o    (side_gain_o),
    .drv_gain_o     (drv_gain_o),
    .cch_en_o       (cch_en_o),
    .dch_en_o       (dch_en_o),
    .dch_wide_o     (dch_wide_o),
    .alaw_o         (alaw_o),
    .signmag_o      (signmag_o),
    .clk_sel_o      (clk_sel_o),
    .cch_data_o     (cch_data_o),
    .dch_data_o     (dch_data_o),
    .loop_en_o      (loop_en_o),
    .loop_pcm_o     (loop_pcm_o)
  );
endmodule

// File: rtl/codec_ctrl_regfile_chk.sv
module codec_ctrl_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_rst_n,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] rdata_o,
  input logic       frame_strobe_i,
  input logic       sdo_oe_o,
  input logic       soft_rst_o,
  input logic       full_pwrdn_o,
  input logic       pd_front_o,
  input logic       pd_drive_o,
  input logic       tx_mute_o,
  input logic       rx_mute_o,
  input logic       alaw_o,
  input logic       loop_en_o,
  input logic [7:0] cch_data_o
);
  AST_HW_RESET_PWRDN: assert property (@(posedge clk_i)
    !rst_ni |-> (full_pwrdn_o && !sdo_oe_o)); // R1

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !rd_en_i |-> (rdata_o == 8'h00)); // R3

  AST_LOOP_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (rd_en_i && addr_i == 3'd7) |-> (rdata_o[7:4] == 4'h0 && rdata_o[1:0] == 2'b00)); // R2

  AST_SRST_ENTRY: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (wr_en_i && addr_i == 3'd3 && wdata_i[5]) |=> soft_rst_o); // R4

  AST_SRST_SIBLINGS_ZERO: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (soft_rst_o && rd_en_i && addr_i == 3'd3) |-> (rdata_o == 8'h20)); // R5

  AST_SRST_HOLD: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (soft_rst_o && !(wr_en_i && addr_i == 3'd3)) |=> soft_rst_o); // R5

  AST_SRST_EXIT_CLEAN: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (soft_rst_o && wr_en_i && addr_i == 3'd3 && !wdata_i[5])
      |=> (!soft_rst_o && !tx_mute_o && !rx_mute_o && !pd_front_o && !pd_drive_o)); // R6

  AST_SRST_OUTPUTS_DEFAULT: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    soft_rst_o |-> (!tx_mute_o && !rx_mute_o && !alaw_o && !loop_en_o
                    && cch_data_o == 8'h00 && !sdo_oe_o)); // R7

  AST_PWRDN_NO_OE: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    full_pwrdn_o |-> !sdo_oe_o); // R8

  AST_OE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !frame_strobe_i |-> !sdo_oe_o); // R9
endmodule

bind codec_ctrl_regfile codec_ctrl_regfile_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .core_rst_n     (core_rst_n),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .wr_en_i        (wr_en_i),
  .rd_en_i        (rd_en_i),
  .rdata_o        (rdata_o),
  .frame_strobe_i (frame_strobe_i),
  .sdo_oe_o       (sdo_oe_o),
  .soft_rst_o     (soft_rst_o),
  .full_pwrdn_o   (full_pwrdn_o),
  .pd_front_o     (pd_front_o),
  .pd_drive_o     (pd_drive_o),
  .tx_mute_o      (tx_mute_o),
  .rx_mute_o      (rx_mute_o),
  .alaw_o         (alaw_o),
  .loop_en_o      (loop_en_o),
  .cch_data_o     (cch_data_o)
);

// File: tb/codec_ctrl_regfile_tb.sv
module codec_ctrl_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] addr_i;
  logic [7:0] wdata_i;
  logic       wr_en_i;
  logic       rd_en_i;
  logic [7:0] rdata_o;
  logic       frame_strobe_i;
  logic       sdo_oe_o, soft_rst_o, full_pwrdn_o, pd_front_o, pd_drive_o;
  logic       tx_mute_o, rx_mute_o, tx_bank_o, rx_bank_o;
  logic [3:0] rx_gain_o, tx_gain_o;
  logic [2:0] side_gain_o, clk_sel_o;
  logic       drv_gain_o, cch_en_o, dch_en_o, dch_wide_o, alaw_o, signmag_o;
  logic [7:0] cch_data_o, dch_data_o;
  logic       loop_en_o, loop_pcm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  codec_ctrl_regfile u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .frame_strobe_i(frame_strobe_i), .sdo_oe_o(sdo_oe_o),
    .soft_rst_o(soft_rst_o), .full_pwrdn_o(full_pwrdn_o),
    .pd_front_o(pd_front_o), .pd_drive_o(pd_drive_o),
    .tx_mute_o(tx_mute_o), .rx_mute_o(rx_mute_o),
    .tx_bank_o(tx_bank_o), .rx_bank_o(rx_bank_o),
    .rx_gain_o(rx_gain_o), .tx_gain_o(tx_gain_o),
    .side_gain_o(side_gain_o), .drv_gain_o(drv_gain_o),
    .cch_en_o(cch_en_o), .dch_en_o(dch_en_o), .dch_wide_o(dch_wide_o),
    .alaw_o(alaw_o), .signmag_o(signmag_o), .clk_sel_o(clk_sel_o),
    .cch_data_o(cch_data_o), .dch_data_o(dch_data_o),
    .loop_en_o(loop_en_o), .loop_pcm_o(loop_pcm_o)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, $sformatf("read addr %0d", a), d, exp);
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; frame_strobe_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1", "pwrdn in hw reset", {7'd0, full_pwrdn_o}, 8'h01);
    check("R1", "oe in hw reset", {7'd0, sdo_oe_o}, 8'h00);
    frame_strobe_i = 1'b0;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    for (int a = 0; a < 8; a++) expect_rd("R1", 3'(a), 8'h00);
    check("R8", "pwrdn after release", {7'd0, full_pwrdn_o}, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] exp [8] = '{8'hFF, 8'h07, 8'h01, 8'hCF, 8'hFF, 8'hFF, 8'hFF, 8'h0C};
    for (int a = 0; a < 8; a++) wr(3'(a), (a == 3) ? 8'hDF : 8'hFF);
    for (int a = 0; a < 8; a++) expect_rd("R2", 3'(a), exp[a]);
    @(negedge clk_i);
    addr_i = 3'd0; rd_en_i = 1'b0;
    #1 check("R3", "idle read", rdata_o, 8'h00);
    apply_reset();
  endtask

  task automatic t_decode();
    wr(3'd0, 8'hA5); wr(3'd1, 8'h05); wr(3'd2, 8'h01); wr(3'd3, 8'h0A);
    wr(3'd4, 8'h9A); wr(3'd5, 8'h3C); wr(3'd6, 8'hC3); wr(3'd7, 8'h04);
    @(negedge clk_i);
    check("R10", "rx_gain", {4'd0, rx_gain_o}, 8'h0A);
    check("R10", "tx_gain", {4'd0, tx_gain_o}, 8'h05);
    check("R10", "side_gain", {5'd0, side_gain_o}, 8'h05);
    check("R10", "drv_gain", {7'd0, drv_gain_o}, 8'h01);
    check("R10", "mute/bank", {4'd0, tx_mute_o, rx_mute_o, tx_bank_o, rx_bank_o}, 8'h0A);
    check("R10", "fmt", {cch_en_o, dch_en_o, dch_wide_o, alaw_o, signmag_o, clk_sel_o}, 8'h9A);
    check("R10", "cch_data", cch_data_o, 8'h3C);
    check("R10", "dch_data", dch_data_o, 8'hC3);
    check("R10", "loop", {6'd0, loop_pcm_o, loop_en_o}, 8'h01);
  endtask

  task automatic t_pwrdn();
    wr(3'd3, 8'h80);
    check("R8", "front only", {7'd0, full_pwrdn_o}, 8'h00);
    wr(3'd3, 8'h40);
    check("R8", "drive only", {7'd0, full_pwrdn_o}, 8'h00);
    wr(3'd3, 8'hC0);
    check("R8", "both", {7'd0, full_pwrdn_o}, 8'h01);
    frame_strobe_i = 1'b1; #1;
    check("R9", "oe when powered down", {7'd0, sdo_oe_o}, 8'h00);
    wr(3'd3, 8'h00);
    check("R9", "oe with strobe", {7'd0, sdo_oe_o}, 8'h01);
    frame_strobe_i = 1'b0; #1;
    check("R9", "oe without strobe", {7'd0, sdo_oe_o}, 8'h00);
  endtask

  task automatic t_soft_reset();
    wr(3'd0, 8'h5A); wr(3'd4, 8'hFF); wr(3'd5, 8'h11); wr(3'd7, 8'h0C);
    wr(3'd3, 8'h2F);
    check("R4", "soft_rst flag", {7'd0, soft_rst_o}, 8'h01);
    expect_rd("R4", 3'd3, 8'h20);
    expect_rd("R4", 3'd0, 8'h00);
    expect_rd("R4", 3'd5, 8'h00);
    frame_strobe_i = 1'b1; #1;
    check("R7", "oe in soft reset", {7'd0, sdo_oe_o}, 8'h00);
    check("R7", "outputs default",
          {tx_mute_o, rx_mute_o, alaw_o, loop_en_o, cch_en_o, pd_front_o, 2'b00}, 8'h00);
    frame_strobe_i = 1'b0;
    wr(3'd5, 8'h77);
    expect_rd("R5", 3'd5, 8'h00);
    wr(3'd3, 8'hEC);
    expect_rd("R5", 3'd3, 8'h20);
    wr(3'd3, 8'h0C);
    check("R6", "soft_rst cleared", {7'd0, soft_rst_o}, 8'h00);
    expect_rd("R6", 3'd3, 8'h00);
    check("R6", "mute not loaded", {6'd0, tx_mute_o, rx_mute_o}, 8'h00);
    wr(3'd3, 8'h0C);
    expect_rd("R6", 3'd3, 8'h0C);
  endtask

  task automatic t_hw_in_soft();
    wr(3'd3, 8'h20);
    check("R11", "soft_rst set", {7'd0, soft_rst_o}, 8'h01);
    apply_reset();
    check("R11", "soft_rst after hw", {7'd0, soft_rst_o}, 8'h00);
    expect_rd("R11", 3'd3, 8'h00);
  endtask

  initial begin
    rst_ni = 1'b0; addr_i = '0; wdata_i = '0; wr_en_i = 1'b0;
    rd_en_i = 1'b0; frame_strobe_i = 1'b0;
    t_reset();
    t_masks();
    t_decode();
    t_pwrdn();
    t_soft_reset();
    t_hw_in_soft();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule